// File: doc/BRIEF.md
# Two-Wire Register Target with Abort-on-STOP

This block is a slave-only two-wire serial port that connects an external bus master to a bank of internal byte registers. It never drives the clock line. It pulls the data line low, or lets it go, through an output-enable. Both bus lines are first brought into the system clock domain through two flip-flops. The system clock must run at least ten times faster than the bus clock. Every byte on the bus is eight bits, sent most significant bit first, and one acknowledge clock follows each byte.

A write transfer has three parts: the device address with the write bit, then a register-pointer byte, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps up by one. To read, the master sets the pointer with a write, issues a repeated START, and sends the address again with the read bit. Bytes come from the pointer, which steps up after each one. The read goes on for as long as the master acknowledges. A STOP is honoured at any bit position and abandons the byte in progress. A STOP that falls in the same clock-high interval as a START is not accepted.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and `reg_we` is 0.
- R2: A START (data falling while the clock is high) or a repeated START begins address reception from any state. After a repeated START, a read returns the byte at the pointer that the preceding write set.
- R3: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged: the block pulls the data line low for the ninth clock. Bit 0 of the address byte selects read (1) or write (0).
- R4: An address byte that does not match gets no acknowledge. The block then ignores all clocks until the next START.
- R5: In a write, the first byte after the address loads the 8-bit pointer. Each later byte gives a one-cycle `reg_we` pulse, with `reg_addr` at the pointer and `reg_wdata` holding the byte. The pointer then steps up by one, wrapping from 0xFF to 0x00. Every write byte is acknowledged.
- R6: In a read, each byte is `reg_rdata` at the pointer, sent most significant bit first, and the pointer steps up by one after each byte. An acknowledge from the master starts the next byte. A non-acknowledge releases the data line and ends the transfer.
- R7: A STOP (data rising while the clock is high) at any bit position sends the block to idle and releases the data line. A partly received byte is never written. Clocks that follow are ignored until a START.
- R8: A STOP in the same clock-high interval as the START before it is ignored, and address reception carries on.
- R9: `sda_oe` and `reg_we` change only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The bench builds the block with its default device address 0x3A. It drives the bus with a clock-high and a clock-low phase of 12 system cycles each, so one bus clock period is 24 system cycles, comfortably above the tenfold minimum. This device address, flipped in bit 0, gives the non-matching case. At this bus rate the bench can afford to reach pointer wrap-around at 0xFF, STOPs cut into the middle of a byte, and a START and STOP inside a single clock-high pulse. Alongside these directed cases, seeded random write and read transfers run with random pointers and lengths.

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_d, sda_d;
  logic       start_hi;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, tx, ptr;
  logic       rw, first, mack;

  wire scl      = scl_m[1];
  wire sda      = sda_m[1];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;
  wire stop_ok  = stop_c & ~start_hi;
  wire in_idle  = (st == S_IDLE);

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      start_hi <= 1'b0;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_d <= scl;
      sda_d <= sda;
      if (start_c) start_hi <= 1'b1;
      else if (!scl) start_hi <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sr <= '0;
      tx <= '0;
      ptr <= '0;
      rw <= 1'b0;
      first <= 1'b0;
      mack <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 8'd1;
      if (start_c) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_oe <= 1'b0;
        first <= 1'b1;
      end else if (stop_ok) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sr <= {sr[6:0], sda};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sr[7:1] == DEV_ADDR) begin
                  rw <= sr[0];
                  sda_oe <= 1'b1;
                  st <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st <= S_WACK;
                if (first) begin
                  ptr <= sr;
                  first <= 1'b0;
                end else begin
                  reg_we <= 1'b1;
                  reg_wdata <= sr;
                end
              end
            end
          end
          S_AACK, S_WACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (st == S_AACK && rw) begin
                st <= S_RD;
                tx <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end else begin
                st <= S_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt <= '0;
                ptr <= ptr + 8'd1;
                st <= S_RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx <= {tx[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda;
            end else if (scl_fall) begin
              if (mack) begin
                st <= S_RD;
                tx <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module twi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic reg_we,
  input logic stop_ok,
  input logic in_idle
);

  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_we_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_s);

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ok |=> (!sda_oe && in_idle));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl), .sda_oe(sda_oe),
  .reg_we(reg_we), .stop_ok(stop_ok), .in_idle(in_idle)
);

// File: tb/sim_twi_reg_slave.sv
`timescale 1ns/1ps
module sim_twi_reg_slave;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_mst = 1'b1, sda_mst = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [0:255];
  logic [7:0] expm [0:255];
  int checks = 0, fails = 0, we_cnt = 0;
  wire sda_line = sda_mst & ~sda_oe;

  always #2 clk = ~clk;

  twi_reg_slave #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_mst), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  function automatic logic [7:0] exp_byte(input logic [7:0] p, input int i);
    return expm[8'(p + 8'(i))];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_mst = 1'b1; tk(H); scl_mst = 1'b1; tk(H);
    sda_mst = 1'b0; tk(H); scl_mst = 1'b0; tk(H);
  endtask

  task automatic bus_stop;
    sda_mst = 1'b0; tk(H); scl_mst = 1'b1; tk(H); sda_mst = 1'b1; tk(H);
  endtask

  task automatic send_bit(input logic b);
    sda_mst = b; tk(H); scl_mst = 1'b1; tk(H); scl_mst = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_mst = 1'b1; tk(H); scl_mst = 1'b1; tk(H/2);
    ack = ~sda_line; tk(H/2); scl_mst = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    sda_mst = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tk(H); scl_mst = 1'b1; tk(H/2); b[i] = sda_line; tk(H/2); scl_mst = 1'b0;
    end
    send_bit(~ack);
    sda_mst = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] p, input int n, input logic [7:0] d [8]);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a); chk(a, "R3 addr ack", a, 1);
    send_byte(p, a); chk(a, "R5 ptr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a); chk(a, "R5 data ack", a, 1);
      expm[8'(p + 8'(i))] = d[i];
    end
    bus_stop;
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n);
    logic a; logic [7:0] b;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(p, a);
    sda_mst = 1'b1; tk(H); scl_mst = 1'b1; tk(H); sda_mst = 1'b0; tk(H); scl_mst = 1'b0; tk(H);
    send_byte({DEV, 1'b1}, a); chk(a, "R2 rstart addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i < n - 1);
      chk(b == exp_byte(p, i), "R6 read data", b, exp_byte(p, i));
    end
    chk(sda_oe == 1'b0, "R6 nack release", sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    logic a; logic [7:0] b; logic [7:0] d [8]; int w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      expm[i] = 8'(i) ^ 8'h5A;
    end
    tk(5);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 reset", {sda_oe, reg_we}, 0);
    rst_n = 1'b1; tk(5);

    d[0] = 8'h11; d[1] = 8'h22;
    w0 = we_cnt;
    wr_txn(8'h10, 2, d);
    chk(we_cnt - w0 == 2, "R5 strobe count", we_cnt - w0, 2);
    rd_txn(8'h10, 2);

    wr_txn(8'h30, 0, d);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    recv_byte(b, 1'b0);
    chk(b == expm[8'h30], "R6 read at current pointer", b, expm[8'h30]);
    bus_stop;

    bus_start;
    send_byte({DEV ^ 7'h01, 1'b0}, a); chk(!a, "R4 mismatch nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R4 ignored after mismatch", a, 0);
    bus_stop;

    w0 = we_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h40, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop;
    chk(we_cnt == w0, "R7 partial byte not written", we_cnt - w0, 0);
    send_byte({DEV, 1'b0}, a); chk(!a, "R7 idle after stop", a, 0);
    tk(H);
    rd_txn(8'h40, 1);

    sda_mst = 1'b1; scl_mst = 1'b1; tk(H);
    sda_mst = 1'b0; tk(H); sda_mst = 1'b1; tk(H); scl_mst = 1'b0; tk(H);
    send_byte({DEV, 1'b0}, a); chk(a, "R8 stop with start ignored", a, 1);
    bus_stop;

    d[0] = 8'hA5; d[1] = 8'h3C;
    wr_txn(8'hFF, 2, d);
    rd_txn(8'hFF, 2);
    chk(mem[8'h00] == 8'h3C, "R5 pointer wrap", mem[8'h00], 8'h3C);

    for (int k = 0; k < 25; k++) begin
      logic [7:0] p; int n;
      p = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      wr_txn(p, n, d);
      rd_txn(8'($urandom % 2 ? p : 8'($urandom)), 1 + int'($urandom % 4));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule